// File: doc/BRIEF.md
# Push-Button Power Request Qualifier

This block turns one push-button input into two kinds of power request: a request to power the system on (leave retention) and a request to power it off (enter retention). Each request type has its own activation mode. A level mode measures how long the button stays at its active level, counted in ticks of a slow timebase. The request is accepted only if that duration falls inside a programmable window. An edge mode fires on the edge that starts the activity.

Each window is given as a minimum and a maximum in coarse units. Both bounds are scaled by a power of two chosen by a shared unit field. The maximum check can be switched off separately for each request type. An optional state monitor remembers whether the system is logically on or off. While it is enabled, only the request that changes that state gets through. The configuration comes in as static input ports. The outputs are single-cycle request pulses in the fast clock domain.

Top module: `btn_pwr_filter`

## Requirements
- R1: Mode codes are 0 = active high level, 1 = active low level, 2 = rising edge, 3 = falling edge. In a level mode a candidate press is evaluated when the button leaves its active level.
- R2: In an edge mode the request fires on the selected edge of the button, whatever the window settings are.
- R3: The press duration is the number of clock cycles in which `tick` is high while the button is active. A level press is rejected if its duration is below min × 2^unit.
- R4: When a channel's maximum check is enabled, a press whose duration is above max × 2^unit is rejected. When the check is disabled, there is no upper bound.
- R5: The on and off channels have independent modes, windows and maximum-check enables.
- R6: A unit value above UNIT_MAX is used as UNIT_MAX.
- R7: The duration counter saturates at its all-ones value instead of wrapping.
- R8: Both request outputs are low after reset. Each request is a pulse one clock cycle wide. It appears two clock cycles after the button change that ends the press (level mode) or forms the edge (edge mode).
- R9: While `bc_enable` is low, no request pulses are produced.
- R10: With the monitor enabled, the logical state starts as off after reset. An on request is emitted only in the off state, and an off request only in the on state. Each emitted on pulse sets the state to on, and each emitted off pulse clears it to off.
- R11: With the monitor disabled, every qualified request is emitted, including an on and an off in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow timebase enable for duration counting |
| btn_in | input | 1 | Button level, synchronous to clk |
| bc_enable | input | 1 | Global enable for request generation |
| mon_en | input | 1 | State monitor enable |
| on_mode | input | 2 | On-request mode code |
| off_mode | input | 2 | Off-request mode code |
| on_min | input | CFG_W | On window minimum (coarse units) |
| on_max | input | CFG_W | On window maximum (coarse units) |
| off_min | input | CFG_W | Off window minimum (coarse units) |
| off_max | input | CFG_W | Off window maximum (coarse units) |
| on_max_en | input | 1 | Enable on-window maximum check |
| off_max_en | input | 1 | Enable off-window maximum check |
| unit | input | UNIT_W | Power-of-two window scale |
| on_req | output | 1 | Power-on request pulse |
| off_req | output | 1 | Power-off request pulse |

## Verification
The bench builds the block with CFG_W = 4 and UNIT_MAX = 3. With these values the duration counter is only 7 bits wide and saturates after 127 ticks. A press of a couple of hundred cycles therefore reaches saturation, and a scaled maximum of 120 sits just below the saturation point. The unit port stays 4 bits wide, so values above the cap can be driven to exercise the clamp. Narrow window fields also let random windows land on short presses, so acceptances and rejections both occur often.

// File: rtl/btn_pwr_pkg.sv
package btn_pwr_pkg;

  typedef enum logic [1:0] {
    ACT_HIGH  = 2'd0,
    ACT_LOW   = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_FALL = 2'd3
  } act_mode_e;

  localparam int NUM_CH = 2;
  localparam int CH_ON  = 0;
  localparam int CH_OFF = 1;

endpackage

// File: rtl/btn_win_qual.sv
module btn_win_qual
  import btn_pwr_pkg::*;
#(
  parameter int CFG_W = 8,
  parameter int UNIT_W = 4,
  parameter int CNT_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              btn_cur,
  input  logic              btn_prev,
  input  act_mode_e         mode,
  input  logic [CFG_W-1:0]  win_min,
  input  logic [CFG_W-1:0]  win_max,
  input  logic              max_en,
  input  logic [UNIT_W-1:0] unit_eff,
  output logic              hit
);

  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic             want_high;
  logic             edge_mode;
  logic             act_cur;
  logic             act_prev;
  logic [CNT_W-1:0] dur_q;
  logic [CNT_W-1:0] dur_d;
  logic             dur_en;
  logic [CNT_W-1:0] lo_bound;
  logic [CNT_W-1:0] hi_bound;
  logic             in_window;

  always_comb begin
    want_high = (mode == ACT_HIGH) || (mode == EDGE_RISE);
    edge_mode = (mode == EDGE_RISE) || (mode == EDGE_FALL);
    act_cur   = (btn_cur == want_high);
    act_prev  = (btn_prev == want_high);
  end

  // duration counter: clears while inactive, counts ticks while active, saturates
  always_comb begin
    dur_en = 1'b0;
    dur_d  = dur_q;
    if (!act_cur) begin
      dur_en = 1'b1;
      dur_d  = '0;
    end else if (tick && (dur_q != CNT_SAT)) begin
      dur_en = 1'b1;
      dur_d  = dur_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_q <= '0;
    end else if (dur_en) begin
      dur_q <= dur_d;
    end
  end

  always_comb begin
    lo_bound  = CNT_W'(win_min) << unit_eff;
    hi_bound  = CNT_W'(win_max) << unit_eff;
    in_window = (dur_q >= lo_bound) && (!max_en || (dur_q <= hi_bound));
  end

  always_comb begin
    if (edge_mode) begin
      hit = act_cur && !act_prev;
    end else begin
      hit = act_prev && !act_cur && in_window;
    end
  end

endmodule

// File: rtl/btn_state_mon.sv
module btn_state_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic mon_en,
  input  logic on_hit,
  input  logic off_hit,
  output logic on_req,
  output logic off_req
);

  logic st_on_q;
  logic st_on_d;
  logic on_ok;
  logic off_ok;

  always_comb begin
    on_ok  = enable && on_hit  && (!mon_en || !st_on_q);
    off_ok = enable && off_hit && (!mon_en ||  st_on_q);
    if (on_ok) begin
      st_on_d = 1'b1;
    end else if (off_ok) begin
      st_on_d = 1'b0;
    end else begin
      st_on_d = st_on_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_on_q <= 1'b0;
      on_req  <= 1'b0;
      off_req <= 1'b0;
    end else begin
      st_on_q <= st_on_d;
      on_req  <= on_ok;
      off_req <= off_ok;
    end
  end

endmodule

// File: rtl/btn_pwr_filter.sv
module btn_pwr_filter
  import btn_pwr_pkg::*;
#(
  parameter int CFG_W = 8,
  parameter int UNIT_W = 4,
  parameter int UNIT_MAX = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              btn_in,
  input  logic              bc_enable,
  input  logic              mon_en,
  input  logic [1:0]        on_mode,
  input  logic [1:0]        off_mode,
  input  logic [CFG_W-1:0]  on_min,
  input  logic [CFG_W-1:0]  on_max,
  input  logic [CFG_W-1:0]  off_min,
  input  logic [CFG_W-1:0]  off_max,
  input  logic              on_max_en,
  input  logic              off_max_en,
  input  logic [UNIT_W-1:0] unit,
  output logic              on_req,
  output logic              off_req
);

  localparam int CNT_W = CFG_W + UNIT_MAX;
  localparam logic [UNIT_W-1:0] UNIT_CAP = UNIT_W'(UNIT_MAX);

  logic              btn_q;
  logic              btn_qq;
  logic [UNIT_W-1:0] unit_eff;
  act_mode_e         ch_mode  [NUM_CH];
  logic [CFG_W-1:0]  ch_min   [NUM_CH];
  logic [CFG_W-1:0]  ch_max   [NUM_CH];
  logic              ch_maxen [NUM_CH];
  logic              ch_hit   [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_q  <= 1'b0;
      btn_qq <= 1'b0;
    end else begin
      btn_q  <= btn_in;
      btn_qq <= btn_q;
    end
  end

  always_comb begin
    unit_eff = (unit > UNIT_CAP) ? UNIT_CAP : unit;
    ch_mode[CH_ON]   = act_mode_e'(on_mode);
    ch_mode[CH_OFF]  = act_mode_e'(off_mode);
    ch_min[CH_ON]    = on_min;
    ch_min[CH_OFF]   = off_min;
    ch_max[CH_ON]    = on_max;
    ch_max[CH_OFF]   = off_max;
    ch_maxen[CH_ON]  = on_max_en;
    ch_maxen[CH_OFF] = off_max_en;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    btn_win_qual #(
      .CFG_W (CFG_W),
      .UNIT_W(UNIT_W),
      .CNT_W (CNT_W)
    ) qual_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .btn_cur (btn_q),
      .btn_prev(btn_qq),
      .mode    (ch_mode[g]),
      .win_min (ch_min[g]),
      .win_max (ch_max[g]),
      .max_en  (ch_maxen[g]),
      .unit_eff(unit_eff),
      .hit     (ch_hit[g])
    );
  end

  btn_state_mon mon_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (bc_enable),
    .mon_en (mon_en),
    .on_hit (ch_hit[CH_ON]),
    .off_hit(ch_hit[CH_OFF]),
    .on_req (on_req),
    .off_req(off_req)
  );

endmodule

// File: rtl/btn_pwr_filter_chk.sv
module btn_pwr_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic bc_enable,
  input logic mon_en,
  input logic on_req,
  input logic off_req
);

  logic seen_on_q;
  logic st_obs;

  always_comb begin
    if (on_req) begin
      st_obs = 1'b1;
    end else if (off_req) begin
      st_obs = 1'b0;
    end else begin
      st_obs = seen_on_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_on_q <= 1'b0;
    end else begin
      seen_on_q <= st_obs;
    end
  end

  // R8
  on_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_req |=> !on_req);

  // R8
  off_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |=> !off_req);

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bc_enable |=> (!on_req && !off_req));

  // R10
  mon_no_reon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && st_obs) |=> !on_req);

  // R10
  mon_no_reoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && !st_obs) |=> !off_req);

endmodule

bind btn_pwr_filter btn_pwr_filter_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bc_enable(bc_enable),
  .mon_en   (mon_en),
  .on_req   (on_req),
  .off_req  (off_req)
);

// File: tb/btn_pwr_filter_tb_top.sv
`timescale 1ns/1ps
module btn_pwr_filter_tb_top;

  localparam int CFG_W = 4;
  localparam int UNIT_W = 4;
  localparam int UNIT_MAX = 3;
  localparam int SAT = (1 << (CFG_W + UNIT_MAX)) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, btn_in, bc_enable, mon_en;
  logic [1:0] on_mode, off_mode;
  logic [CFG_W-1:0] on_min, on_max, off_min, off_max;
  logic on_max_en, off_max_en;
  logic [UNIT_W-1:0] unit;
  logic on_req, off_req;

  int n_total = 0;
  int n_fail = 0;
  int on_cnt = 0;
  int off_cnt = 0;

  always #10 clk = ~clk;

  btn_pwr_filter #(.CFG_W(CFG_W), .UNIT_W(UNIT_W), .UNIT_MAX(UNIT_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn_in(btn_in),
    .bc_enable(bc_enable), .mon_en(mon_en),
    .on_mode(on_mode), .off_mode(off_mode),
    .on_min(on_min), .on_max(on_max), .off_min(off_min), .off_max(off_max),
    .on_max_en(on_max_en), .off_max_en(off_max_en), .unit(unit),
    .on_req(on_req), .off_req(off_req)
  );

  always @(negedge clk) begin
    if (on_req) on_cnt++;
    if (off_req) off_cnt++;
  end

  function automatic bit qual(int dur, int mn, int mx, bit men, int un);
    int u = (un > UNIT_MAX) ? UNIT_MAX : un;
    int d = (dur > SAT) ? SAT : dur;
    return (d >= (mn << u)) && (!men || d <= (mx << u));
  endfunction

  task automatic check(string tag, int got, int exp);
    n_total++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
  endtask

  // both channels made unable to fire
  task automatic block();
    on_mode = 2'd0; off_mode = 2'd0;
    on_min = '1; on_max = '0; on_max_en = 1'b1;
    off_min = '1; off_max = '0; off_max_en = 1'b1;
  endtask

  task automatic set_idle(bit lvl);
    block();
    @(negedge clk);
    btn_in = lvl;
    repeat (4) @(negedge clk);
  endtask

  task automatic press(bit lvl, int n, int eon, int eoff, string tag);
    int o0 = on_cnt;
    int f0 = off_cnt;
    @(negedge clk);
    btn_in = lvl;
    repeat (n) @(negedge clk);
    btn_in = !lvl;
    repeat (5) @(negedge clk);
    check({tag, " on"}, on_cnt - o0, eon);
    check({tag, " off"}, off_cnt - f0, eoff);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: got hang exp completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; btn_in = 1'b0; bc_enable = 1'b1; mon_en = 1'b0;
    unit = '0;
    block();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset on_req", int'(on_req), 0);
    check("R8 reset off_req", int'(off_req), 0);

    // R10: monitor starts off, so an off request is refused
    mon_en = 1'b1;
    off_mode = 2'd0; off_min = 4'd1; off_max = 4'd15; off_max_en = 1'b1;
    press(1'b1, 5, 0, 0, "R10 initial off refused");

    // R2 edge modes ignore impossible windows; R10 on then off
    set_idle(1'b0);
    on_mode = 2'd2; off_mode = 2'd3;
    press(1'b1, 3, 1, 1, "R2 edge pair");

    // R10 level: both qualify, monitor alternates
    set_idle(1'b0);
    on_mode = 2'd0; on_min = 4'd1; on_max = 4'd15; on_max_en = 1'b1;
    off_mode = 2'd0; off_min = 4'd1; off_max = 4'd15; off_max_en = 1'b1;
    press(1'b1, 4, 1, 0, "R10 first");
    press(1'b1, 4, 0, 1, "R10 second");
    press(1'b1, 4, 1, 0, "R10 third");

    // R11 monitor disabled: both fire
    mon_en = 1'b0;
    press(1'b1, 4, 1, 1, "R11 both");

    // R9 global disable
    bc_enable = 1'b0;
    press(1'b1, 4, 0, 0, "R9 disabled");
    bc_enable = 1'b1;

    // R1 low-level mode, R3/R4 window edges
    set_idle(1'b1);
    on_mode = 2'd1; on_min = 4'd2; on_max = 4'd5; on_max_en = 1'b1; unit = 4'd0;
    press(1'b0, 3, 1, 0, "R1 low level");
    press(1'b0, 5, 1, 0, "R4 at max");
    press(1'b0, 6, 0, 0, "R4 above max");
    press(1'b0, 1, 0, 0, "R3 below min");
    press(1'b0, 2, 1, 0, "R3 at min");
    on_max_en = 1'b0;
    press(1'b0, 20, 1, 0, "R4 max disabled");

    // R6 unit clamp: 7 acts as 3, min 2 -> 16
    set_idle(1'b0);
    on_mode = 2'd0; on_min = 4'd2; on_max_en = 1'b0; unit = 4'd7;
    press(1'b1, 20, 1, 0, "R6 clamp accept");
    press(1'b1, 12, 0, 0, "R6 clamp reject");

    // R7 saturation: min 15<<3 = 120, press 200
    on_min = 4'd15; unit = 4'd3;
    press(1'b1, 200, 1, 0, "R7 saturate no wrap");
    on_max = 4'd15; on_max_en = 1'b1;
    press(1'b1, 200, 0, 0, "R7 saturate above max");

    // R5 independent windows
    unit = 4'd0;
    on_min = 4'd1; on_max = 4'd3; on_max_en = 1'b1;
    off_mode = 2'd0; off_min = 4'd6; off_max = 4'd9; off_max_en = 1'b1;
    press(1'b1, 2, 1, 0, "R5 on window");
    press(1'b1, 7, 0, 1, "R5 off window");

    // R3 duration counts only ticked cycles
    set_idle(1'b0);
    on_mode = 2'd0; on_min = 4'd1; on_max_en = 1'b0;
    tick = 1'b0;
    press(1'b1, 10, 0, 0, "R3 no ticks");
    on_min = 4'd0;
    press(1'b1, 10, 1, 0, "R3 no ticks min zero");
    tick = 1'b1;

    // random level presses on the on channel
    begin
      int seed_dummy;
      seed_dummy = $urandom(1234);
      for (int i = 0; i < 30; i++) begin
        bit lvl = $urandom_range(0, 1) != 0;
        int mn = $urandom_range(0, 15);
        int mx = $urandom_range(0, 15);
        bit men = $urandom_range(0, 1) != 0;
        int un = $urandom_range(0, 5);
        int dur = $urandom_range(1, 60);
        set_idle(!lvl);
        on_mode = lvl ? 2'd0 : 2'd1;
        on_min = CFG_W'(mn); on_max = CFG_W'(mx); on_max_en = men;
        unit = UNIT_W'(un);
        press(lvl, dur, qual(dur, mn, mx, men, un) ? 1 : 0, 0, "R3 R4 R6 random");
      end
    end

    summary();
    $finish;
  end

endmodule